// File: doc/BRIEF.md
# Byte-to-Word Host Port Bridge

This block joins an 8-bit host processor bus to the 24-bit word side of a signal-processing core. The host sees eight byte offsets: an interrupt control byte, a command vector byte, a read-only status byte, an interrupt vector byte, an unused offset and three data bytes that carry one 24-bit word (high, middle, low). The core sees a small control register, a status vector and two 24-bit data registers, one for each direction.

Each direction has its own double-buffered handshake. An access to the low data byte is what moves a word. Empty and full flags on the two sides are tied together, so that freeing one buffer at once lets a waiting word move forward. The bridge raises a host interrupt when a masked host request appears, raises interrupts toward the core when their enables are set, and passes host flags and host commands across.

After reset the core is held. The first 512 words written by the host go to program memory at consecutive addresses and do not enter the handshake. The last of them releases the core.

Top module: `hostport_bridge`

## Requirements
- R1: After reset the command vector (offset 1) reads 0x12, the interrupt vector (offset 3) reads 0x0F, the host status byte (offset 2) reads 0x06 and `d_status` is 0x02. Host status bits: 0 = receive full, 1 = transmit empty, 2 = transfer ready, 7 = host request, others zero. `d_status` bits: 0 = core receive full, 1 = core transmit empty, 2 = command pending, 3 = host flag 0, 4 = host flag 1. `core_run` is 0.
- R2: A host write to the low byte (offset 7) while transfer ready is clear clears host transmit empty. As soon as core receive full is clear, the word held in offsets 5/6/7 moves to `d_rxdata`, core receive full is set and host transmit empty is set again.
- R3: A `d_rd` pulse clears core receive full and, in the same update, retries a waiting host-to-core word.
- R4: A `d_wr` pulse clears core transmit empty. While host receive full is clear, the word is copied into the host receive bytes (offsets 5/6/7 on read), core transmit empty is set and host receive full is set.
- R5: A host read strobe on offset 7 clears host receive full and, in the same update, retries a waiting core-to-host word.
- R6: Transfer ready is host transmit empty AND NOT core receive full. A low-byte write while it is set places the word directly in `d_rxdata` and sets core receive full. Host transmit empty stays set.
- R7: Host request = OR of (interrupt control bits 1:0 AND host status bits 1:0). `h_irq` is high for exactly one cycle, in the cycle after the update that makes the request rise.
- R8: A write to offset 0 stores the value with bit 2 cleared. Its bits 3 and 4 appear as `d_status` bits 3 and 4.
- R9: A write to offset 1 stores the value AND 0x9F. Bit 7 of the written value sets command pending and bit 7 clear clears it.
- R10: `d_irq_rx`, `d_irq_tx` and `d_irq_cmd` pulse for a receive word, a transmit hand-off or a command only when control bit 0, 1 or 2 (written through `d_ctl_wdata`) is set.
- R11: Host writes to offsets 2 and 4 have no effect. Offset 4 always reads 0x00.
- R12: While `core_run` is 0, each low-byte write emits `boot_we` with the next address (from 0) and the assembled word, and leaves the handshake flags unchanged. The write at address 511 sets `core_run`, which then stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs | input | 1 | Host access select |
| h_we | input | 1 | Host write (1) or read (0) |
| h_rd | input | 1 | Host read strobe, consumes data on offset 7 |
| h_addr | input | 3 | Host byte offset |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for `h_addr` |
| h_irq | output | 1 | One-cycle host interrupt pulse |
| d_ctl_we | input | 1 | Core control register write |
| d_ctl_wdata | input | 3 | Interrupt enables: receive, transmit, command |
| d_rd | input | 1 | Core reads its receive register |
| d_wr | input | 1 | Core writes its transmit register |
| d_wdata | input | 24 | Core transmit word |
| d_rxdata | output | 24 | Core receive register |
| d_status | output | 5 | Core-side status vector |
| d_irq_rx | output | 1 | Receive interrupt pulse |
| d_irq_tx | output | 1 | Transmit interrupt pulse |
| d_irq_cmd | output | 1 | Host command interrupt pulse |
| boot_we | output | 1 | Program memory write strobe |
| boot_addr | output | 9 | Program memory address |
| boot_data | output | 24 | Program memory word |
| core_run | output | 1 | Core released from bootstrap |

## Verification
On every cycle the assertions check the flag coupling: a core read that frees the receive register either empties it or takes in the waiting host word, a core write into a free host buffer always lands, a host read with nothing waiting leaves receive full clear, and a command write always sets the pending flag. They also keep `h_irq` to a single cycle, gate the receive interrupt on its enable, and hold `core_run` once it is set. The exact data values, the stored register masks, the read-only offsets and the 512-word bootstrap address sequence can only be shown by the bench's scenarios, which compare full words and bytes against values worked out from the requirements.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 24;
    localparam int HADDR_W = 3;
    localparam int DCTL_W  = 3;
    localparam int DSTAT_W = 5;

    typedef enum logic [HADDR_W-1:0] {
        OFS_ICTL = 3'd0,
        OFS_CMDV = 3'd1,
        OFS_HSTS = 3'd2,
        OFS_IVEC = 3'd3,
        OFS_GAP  = 3'd4,
        OFS_DHI  = 3'd5,
        OFS_DMID = 3'd6,
        OFS_DLO  = 3'd7
    } hofs_e;

    // host status bit positions
    localparam int HS_RXF  = 0;
    localparam int HS_TXE  = 1;
    localparam int HS_TRDY = 2;
    localparam int HS_REQ  = 7;

    // core control enables
    localparam int CC_RXIE  = 0;
    localparam int CC_TXIE  = 1;
    localparam int CC_CMDIE = 2;

    localparam logic [BYTE_W-1:0] ICTL_MASK = 8'hFB;
    localparam logic [BYTE_W-1:0] CMDV_MASK = 8'h9F;
    localparam logic [BYTE_W-1:0] CMDV_INIT = 8'h12;
    localparam logic [BYTE_W-1:0] IVEC_INIT = 8'h0F;

    typedef struct packed {
        logic txde;  // host transmit empty
        logic rxdf;  // host receive full
        logic hrdf;  // core receive full
        logic htde;  // core transmit empty
    } hs_flags_t;

    localparam hs_flags_t FLAGS_INIT = '{txde: 1'b1, rxdf: 1'b0, hrdf: 1'b0, htde: 1'b1};

    function automatic logic [BYTE_W-1:0] word_byte(input logic [WORD_W-1:0] w, input int idx);
        return w[idx*BYTE_W +: BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] host_status(input hs_flags_t f, input logic req);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[HS_RXF]  = f.rxdf;
        s[HS_TXE]  = f.txde;
        s[HS_TRDY] = f.txde & ~f.hrdf;
        s[HS_REQ]  = req;
        return s;
    endfunction
endpackage

// File: rtl/hpb_host_regs.sv
module hpb_host_regs
    import hpb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [HADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   ictl,
    output logic [BYTE_W-1:0]   cmdv,
    output logic [BYTE_W-1:0]   ivec,
    output logic                cmd_pend,
    output logic                cmd_set,
    output logic [WORD_W-1:0]   tx_word
);
    logic [BYTE_W-1:0] tx_hi, tx_mid, tx_lo;
    logic              lo_wr;

    assign lo_wr   = wr && (hofs_e'(addr) == OFS_DLO);
    assign cmd_set = wr && (hofs_e'(addr) == OFS_CMDV) && wdata[7];
    assign tx_word = {tx_hi, tx_mid, lo_wr ? wdata : tx_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            ictl     <= '0;
            cmdv     <= CMDV_INIT;
            ivec     <= IVEC_INIT;
            cmd_pend <= 1'b0;
            tx_hi    <= '0;
            tx_mid   <= '0;
            tx_lo    <= '0;
        end else if (wr) begin
            case (hofs_e'(addr))
                OFS_ICTL: ictl <= wdata & ICTL_MASK;
                OFS_CMDV: begin
                    cmdv     <= wdata & CMDV_MASK;
                    cmd_pend <= wdata[7];
                end
                OFS_IVEC: ivec   <= wdata;
                OFS_DHI:  tx_hi  <= wdata;
                OFS_DMID: tx_mid <= wdata;
                OFS_DLO:  tx_lo  <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hpb_xfer.sv
module hpb_xfer
    import hpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_low,
    input  logic              host_rd_low,
    input  logic [WORD_W-1:0] host_word,
    input  logic              dsp_rd,
    input  logic              dsp_wr,
    input  logic [WORD_W-1:0] dsp_word,
    output hs_flags_t         flags,
    output logic [WORD_W-1:0] dsp_rx,
    output logic [WORD_W-1:0] host_rx,
    output logic              rx_evt,
    output logic              tx_evt
);
    hs_flags_t         f_q, f_n;
    logic [WORD_W-1:0] to_dsp_q, to_dsp_n;
    logic [WORD_W-1:0] dtx_q, dtx_n;
    logic [WORD_W-1:0] hrx_q, hrx_n;

    // Updates are applied in order within one cycle so a freed buffer
    // lets the waiting word move in the same update.
    always_comb begin
        f_n      = f_q;
        to_dsp_n = to_dsp_q;
        dtx_n    = dtx_q;
        hrx_n    = hrx_q;
        rx_evt   = 1'b0;
        tx_evt   = 1'b0;

        if (dsp_rd)      f_n.hrdf = 1'b0;
        if (dsp_wr) begin
            f_n.htde = 1'b0;
            dtx_n    = dsp_word;
        end
        if (host_rd_low) f_n.rxdf = 1'b0;

        if (host_wr_low) begin
            if (f_n.txde && !f_n.hrdf) begin
                to_dsp_n = host_word;
                f_n.hrdf = 1'b1;
                rx_evt   = 1'b1;
            end else begin
                f_n.txde = 1'b0;
            end
        end

        if (!f_n.txde && !f_n.hrdf) begin
            to_dsp_n = host_word;
            f_n.hrdf = 1'b1;
            f_n.txde = 1'b1;
            rx_evt   = 1'b1;
        end

        if (!f_n.rxdf && !f_n.htde) begin
            hrx_n    = dtx_n;
            f_n.htde = 1'b1;
            f_n.rxdf = 1'b1;
            tx_evt   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q      <= FLAGS_INIT;
            to_dsp_q <= '0;
            dtx_q    <= '0;
            hrx_q    <= '0;
        end else begin
            f_q      <= f_n;
            to_dsp_q <= to_dsp_n;
            dtx_q    <= dtx_n;
            hrx_q    <= hrx_n;
        end
    end

    assign flags   = f_q;
    assign dsp_rx  = to_dsp_q;
    assign host_rx = hrx_q;
endmodule

// File: rtl/hpb_boot.sv
module hpb_boot
    import hpb_pkg::*;
#(
    parameter int BOOT_WORDS = 512,
    localparam int AW = $clog2(BOOT_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              we,
    output logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] data,
    output logic              running
);
    logic [AW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
            we      <= 1'b0;
            addr    <= '0;
            data    <= '0;
        end else begin
            we <= 1'b0;
            if (load && !running) begin
                we   <= 1'b1;
                addr <= cnt;
                data <= word;
                if (cnt == AW'(BOOT_WORDS - 1)) running <= 1'b1;
                else                             cnt     <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
    import hpb_pkg::*;
#(
    parameter int BOOT_WORDS = 512,
    localparam int BAW = $clog2(BOOT_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_cs,
    input  logic               h_we,
    input  logic               h_rd,
    input  logic [HADDR_W-1:0] h_addr,
    input  logic [BYTE_W-1:0]  h_wdata,
    output logic [BYTE_W-1:0]  h_rdata,
    output logic               h_irq,
    input  logic               d_ctl_we,
    input  logic [DCTL_W-1:0]  d_ctl_wdata,
    input  logic               d_rd,
    input  logic               d_wr,
    input  logic [WORD_W-1:0]  d_wdata,
    output logic [WORD_W-1:0]  d_rxdata,
    output logic [DSTAT_W-1:0] d_status,
    output logic               d_irq_rx,
    output logic               d_irq_tx,
    output logic               d_irq_cmd,
    output logic               boot_we,
    output logic [BAW-1:0]     boot_addr,
    output logic [WORD_W-1:0]  boot_data,
    output logic               core_run
);
    logic              host_wr, lo_wr, rd_low, xfer_wr_low, cmd_set, cmd_pend;
    logic [BYTE_W-1:0] ictl, cmdv, ivec;
    logic [WORD_W-1:0] tx_word, host_rx;
    logic [DCTL_W-1:0] dctl;
    hs_flags_t         fl;
    logic              rx_evt, tx_evt, hreq, hreq_prev;

    assign host_wr     = h_cs && h_we;
    assign lo_wr       = host_wr && (hofs_e'(h_addr) == OFS_DLO);
    assign rd_low      = h_cs && !h_we && h_rd && (hofs_e'(h_addr) == OFS_DLO);
    assign xfer_wr_low = lo_wr && core_run;

    hpb_host_regs u_regs (
        .clk(clk), .rst(rst), .wr(host_wr), .addr(h_addr), .wdata(h_wdata),
        .ictl(ictl), .cmdv(cmdv), .ivec(ivec), .cmd_pend(cmd_pend),
        .cmd_set(cmd_set), .tx_word(tx_word)
    );

    hpb_xfer u_xfer (
        .clk(clk), .rst(rst), .host_wr_low(xfer_wr_low), .host_rd_low(rd_low),
        .host_word(tx_word), .dsp_rd(d_rd), .dsp_wr(d_wr), .dsp_word(d_wdata),
        .flags(fl), .dsp_rx(d_rxdata), .host_rx(host_rx),
        .rx_evt(rx_evt), .tx_evt(tx_evt)
    );

    hpb_boot #(.BOOT_WORDS(BOOT_WORDS)) u_boot (
        .clk(clk), .rst(rst), .load(lo_wr), .word(tx_word),
        .we(boot_we), .addr(boot_addr), .data(boot_data), .running(core_run)
    );

    // host request from the masked status, edge gives the interrupt pulse
    assign hreq  = |(ictl[1:0] & {fl.txde, fl.rxdf});
    assign h_irq = hreq && !hreq_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            dctl      <= '0;
            hreq_prev <= 1'b0;
            d_irq_rx  <= 1'b0;
            d_irq_tx  <= 1'b0;
            d_irq_cmd <= 1'b0;
        end else begin
            if (d_ctl_we) dctl <= d_ctl_wdata;
            hreq_prev <= hreq;
            d_irq_rx  <= rx_evt  && dctl[CC_RXIE];
            d_irq_tx  <= tx_evt  && dctl[CC_TXIE];
            d_irq_cmd <= cmd_set && dctl[CC_CMDIE];
        end
    end

    assign d_status = {ictl[4], ictl[3], cmd_pend, fl.htde, fl.hrdf};

    always_comb begin
        case (hofs_e'(h_addr))
            OFS_ICTL: h_rdata = ictl;
            OFS_CMDV: h_rdata = cmdv;
            OFS_HSTS: h_rdata = host_status(fl, hreq);
            OFS_IVEC: h_rdata = ivec;
            OFS_DHI:  h_rdata = word_byte(host_rx, 2);
            OFS_DMID: h_rdata = word_byte(host_rx, 1);
            OFS_DLO:  h_rdata = word_byte(host_rx, 0);
            default:  h_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hpb_checker.sv
module hpb_checker (
    input logic clk,
    input logic rst,
    input logic d_rd,
    input logic d_wr,
    input logic h_rd_low,
    input logic h_wr_low,
    input logic cmd_set,
    input logic txde,
    input logic rxdf,
    input logic hrdf,
    input logic htde,
    input logic hcp,
    input logic ctl_rx_en,
    input logic d_irq_rx,
    input logic h_irq,
    input logic boot_we,
    input logic core_run
);
    p_retry_r2: assert property (@(posedge clk) disable iff (rst)
        (d_rd && hrdf && !txde) |=> (hrdf && txde));

    p_dsp_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (d_rd && txde && !h_wr_low) |=> !hrdf);

    p_d2h_r4: assert property (@(posedge clk) disable iff (rst)
        (d_wr && !rxdf) |=> (rxdf && htde));

    p_host_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (h_rd_low && htde && !d_wr) |=> !rxdf);

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        h_irq |=> !h_irq);

    p_cmd_flag_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_set |=> hcp);

    p_rx_gate_r10: assert property (@(posedge clk) disable iff (rst)
        d_irq_rx |-> $past(ctl_rx_en));

    p_run_hold_r12: assert property (@(posedge clk) disable iff (rst)
        core_run |=> core_run);

    p_boot_only_r12: assert property (@(posedge clk) disable iff (rst)
        boot_we |-> !$past(core_run));
endmodule

bind hostport_bridge hpb_checker u_chk (
    .clk(clk), .rst(rst), .d_rd(d_rd), .d_wr(d_wr),
    .h_rd_low(rd_low), .h_wr_low(xfer_wr_low), .cmd_set(cmd_set),
    .txde(fl.txde), .rxdf(fl.rxdf), .hrdf(fl.hrdf), .htde(fl.htde),
    .hcp(cmd_pend), .ctl_rx_en(dctl[0]), .d_irq_rx(d_irq_rx),
    .h_irq(h_irq), .boot_we(boot_we), .core_run(core_run)
);

// File: tb/sim_hostport_bridge.sv
`timescale 1ns/1ps
module sim_hostport_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_cs = 1'b0, h_we = 1'b0, h_rd = 1'b0;
    logic [2:0]  h_addr = 3'd0;
    logic [7:0]  h_wdata = 8'd0;
    logic [7:0]  h_rdata;
    logic        h_irq;
    logic        d_ctl_we = 1'b0;
    logic [2:0]  d_ctl_wdata = 3'd0;
    logic        d_rd = 1'b0, d_wr = 1'b0;
    logic [23:0] d_wdata = 24'd0;
    logic [23:0] d_rxdata;
    logic [4:0]  d_status;
    logic        d_irq_rx, d_irq_tx, d_irq_cmd;
    logic        boot_we;
    logic [8:0]  boot_addr;
    logic [23:0] boot_data;
    logic        core_run;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hostport_bridge u0 (
        .clk(clk), .rst(rst), .h_cs(h_cs), .h_we(h_we), .h_rd(h_rd),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
        .d_ctl_we(d_ctl_we), .d_ctl_wdata(d_ctl_wdata), .d_rd(d_rd), .d_wr(d_wr),
        .d_wdata(d_wdata), .d_rxdata(d_rxdata), .d_status(d_status),
        .d_irq_rx(d_irq_rx), .d_irq_tx(d_irq_tx), .d_irq_cmd(d_irq_cmd),
        .boot_we(boot_we), .boot_addr(boot_addr), .boot_data(boot_data),
        .core_run(core_run)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        h_cs = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_cs = 1'b0; h_we = 1'b0;
    endtask

    task automatic host_word(input logic [23:0] w);
        host_wr(3'd5, w[23:16]);
        host_wr(3'd6, w[15:8]);
        host_wr(3'd7, w[7:0]);
    endtask

    task automatic host_peek(input logic [2:0] a, output logic [7:0] d);
        h_addr = a;
        #0.5;
        d = h_rdata;
    endtask

    task automatic host_pop();
        @(negedge clk);
        h_cs = 1'b1; h_we = 1'b0; h_rd = 1'b1; h_addr = 3'd7;
        @(negedge clk);
        h_cs = 1'b0; h_rd = 1'b0;
    endtask

    task automatic dsp_read();
        @(negedge clk); d_rd = 1'b1;
        @(negedge clk); d_rd = 1'b0;
    endtask

    task automatic dsp_write(input logic [23:0] w);
        @(negedge clk); d_wr = 1'b1; d_wdata = w;
        @(negedge clk); d_wr = 1'b0;
    endtask

    task automatic set_ctl(input logic [2:0] v);
        @(negedge clk); d_ctl_we = 1'b1; d_ctl_wdata = v;
        @(negedge clk); d_ctl_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        host_peek(3'd1, b); check("R1 command vector", b, 8'h12);
        host_peek(3'd3, b); check("R1 interrupt vector", b, 8'h0F);
        host_peek(3'd2, b); check("R1 host status", b, 8'h06);
        check("R1 core status", d_status, 5'h02);
        check("R1 core_run", core_run, 1'b0);
    endtask

    task automatic t_boot();
        logic [7:0] b;
        host_word(24'h123456);
        check("R12 first strobe", boot_we, 1'b1);
        check("R12 first addr", boot_addr, 9'd0);
        check("R12 first word", boot_data, 24'h123456);
        host_peek(3'd2, b); check("R12 flags untouched", b, 8'h06);
        check("R12 core status untouched", d_status, 5'h02);
        for (int i = 1; i < 511; i++) host_wr(3'd7, 8'(i));
        check("R12 addr 510", boot_addr, 9'd510);
        check("R12 held before last", core_run, 1'b0);
        host_wr(3'd7, 8'hAB);
        check("R12 last addr", boot_addr, 9'd511);
        check("R12 last word", boot_data, 24'h1234AB);
        check("R12 released", core_run, 1'b1);
        @(negedge clk);
        check("R12 strobe ends", boot_we, 1'b0);
    endtask

    task automatic t_direct();
        logic [7:0] b;
        set_ctl(3'b001);
        host_word(24'hABCDEF);
        check("R6 direct word", d_rxdata, 24'hABCDEF);
        check("R6 receive full", d_status[0], 1'b1);
        check("R10 rx irq enabled", d_irq_rx, 1'b1);
        host_peek(3'd2, b); check("R6 status after direct", b, 8'h02);
    endtask

    task automatic t_pending();
        logic [7:0] b;
        host_word(24'h112233);
        host_peek(3'd2, b); check("R2 transmit empty cleared", b, 8'h00);
        check("R2 word waits", d_rxdata, 24'hABCDEF);
        dsp_read();
        check("R3 retry word", d_rxdata, 24'h112233);
        check("R3 retry full", d_status[0], 1'b1);
        check("R10 rx irq on retry", d_irq_rx, 1'b1);
        host_peek(3'd2, b); check("R2 transmit empty again", b, 8'h02);
        dsp_read();
        host_peek(3'd2, b); check("R3 read clears", b, 8'h06);
        check("R3 core status", d_status, 5'h02);
    endtask

    task automatic t_d2h();
        logic [7:0] b;
        set_ctl(3'b010);
        dsp_write(24'h445566);
        host_peek(3'd2, b); check("R4 host receive full", b, 8'h07);
        check("R4 core transmit empty", d_status, 5'h02);
        check("R10 tx irq enabled", d_irq_tx, 1'b1);
        host_peek(3'd5, b); check("R4 high byte", b, 8'h44);
        host_peek(3'd6, b); check("R4 mid byte", b, 8'h55);
        host_peek(3'd7, b); check("R4 low byte", b, 8'h66);
        dsp_write(24'h778899);
        check("R4 transmit waits", d_status, 5'h00);
        host_peek(3'd7, b); check("R4 old byte kept", b, 8'h66);
        host_pop();
        host_peek(3'd5, b); check("R5 retry high", b, 8'h77);
        host_peek(3'd7, b); check("R5 retry low", b, 8'h99);
        check("R5 transmit empty set", d_status, 5'h02);
        host_pop();
        host_peek(3'd2, b); check("R5 read clears", b, 8'h06);
    endtask

    task automatic t_hreq();
        logic [7:0] b;
        host_wr(3'd0, 8'h01);
        check("R7 no request", h_irq, 1'b0);
        host_wr(3'd0, 8'h02);
        check("R7 pulse on rise", h_irq, 1'b1);
        host_peek(3'd2, b); check("R7 request bit", b, 8'h86);
        @(negedge clk);
        check("R7 pulse one cycle", h_irq, 1'b0);
        host_wr(3'd0, 8'h1C);
        host_peek(3'd0, b); check("R8 bit 2 dropped", b, 8'h18);
        check("R8 host flags", d_status, 5'h1A);
        host_peek(3'd2, b); check("R7 request gone", b, 8'h06);
        host_wr(3'd0, 8'h01);
        dsp_write(24'h000001);
        check("R7 pulse on receive full", h_irq, 1'b1);
        host_pop();
        host_wr(3'd0, 8'h00);
        check("R8 flags cleared", d_status, 5'h02);
    endtask

    task automatic t_cmd();
        logic [7:0] b;
        set_ctl(3'b000);
        host_wr(3'd1, 8'hFF);
        host_peek(3'd1, b); check("R9 masked store", b, 8'h9F);
        check("R9 pending set", d_status, 5'h06);
        check("R10 cmd irq disabled", d_irq_cmd, 1'b0);
        host_wr(3'd1, 8'h05);
        host_peek(3'd1, b); check("R9 plain store", b, 8'h05);
        check("R9 pending cleared", d_status, 5'h02);
        set_ctl(3'b100);
        host_wr(3'd1, 8'h81);
        check("R10 cmd irq enabled", d_irq_cmd, 1'b1);
        host_peek(3'd1, b); check("R9 store with bit 7", b, 8'h81);
        host_wr(3'd1, 8'h00);
        set_ctl(3'b000);
        host_word(24'h010203);
        check("R10 rx irq disabled", d_irq_rx, 1'b0);
        check("R6 direct word 2", d_rxdata, 24'h010203);
        dsp_read();
    endtask

    task automatic t_readonly();
        logic [7:0] b;
        host_wr(3'd2, 8'hFF);
        host_peek(3'd2, b); check("R11 status write ignored", b, 8'h06);
        host_wr(3'd4, 8'hAA);
        host_peek(3'd4, b); check("R11 gap reads zero", b, 8'h00);
        check("R11 core status unchanged", d_status, 5'h02);
        host_wr(3'd3, 8'h3C);
        host_peek(3'd3, b); check("R11 vector writable", b, 8'h3C);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_boot();
        t_direct();
        t_pending();
        t_d2h();
        t_hreq();
        t_cmd();
        t_readonly();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule